// File: doc/BRIEF.md
# Class-Partitioned Cache Tag and Victim Controller

This block holds the tags, valid bits and replacement state of a small set-associative cache. Its victim choice is fenced by a class of service. Every request names a set, a tag and the class of its requester. The lookup compares the tag against every way of the set, whatever the class, so any resident line can hit. A miss may only allocate into ways that the requester's class is allowed to use. Each class holds its own way-allocation mask, and a small config port rewrites those masks. Because of this, traffic from one class cannot push out lines placed in ways that only another class owns.

Among the permitted ways, an empty way is taken first. When none is empty, a tree pseudo-LRU walk picks the victim, steered away from forbidden halves of the tree. The response comes one cycle after the request. It carries the hit flag, the way that hit or was filled, and the tag of any line that the fill displaced. A class whose mask is empty gets an allocation error on a miss, and nothing is filled. The data array and the path to memory are outside the block.

Top module: `wp_cache_ctrl`

## Requirements
- R1: A request hits when any valid way of the addressed set holds the request tag, regardless of the requester's mask; `rsp_hit_o` is 1 and `rsp_way_o` is that way.
- R2: `req_ready_o` is always 1. Each accepted request produces exactly one response with `rsp_valid_o` high in the following cycle, and `rsp_valid_o` is low in any other cycle.
- R3: A miss fills only a way whose bit is set in the requester's mask (bit w of a mask = way w), writing the tag and setting the valid bit; the filled way is reported on `rsp_way_o`.
- R4: If any permitted way of the set is invalid, the fill uses the lowest-numbered such way.
- R5: If all permitted ways are valid, the victim comes from a tree pseudo-LRU with WAYS-1 bits per set, stored in heap order (node n has children 2n+1 and 2n+2). A node bit of 0 points the search at the lower half of its range and 1 at the upper half. The search follows the bit unless that half holds no permitted way, in which case it takes the other half.
- R6: A hit and a fill both touch the pseudo-LRU of the set: every node on the path to the touched way is set to point at the half not containing it. After reset all node bits are 0.
- R7: On a fill whose victim was valid, `rsp_evict_valid_o` is 1 and `rsp_evict_tag_o` carries the old tag; otherwise both are 0.
- R8: A miss from a class whose mask is all zero sets `alloc_error_o`, fills nothing and leaves all lines unchanged; `alloc_error_o` is 0 for every other response.
- R9: After reset, with the secure default enabled, the highest-numbered class may allocate only into the top two ways (mask 8'hC0 at 8 ways) and every other class only into the remaining ways (8'h3F). With the default disabled every mask is all ones.
- R10: A mask write takes effect for requests from the next cycle on; a request in the same cycle as the write uses the old mask. Lines in ways no longer permitted stay valid and still hit.
- R11: During and right after reset every line is invalid and no response is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Lookup request valid |
| req_ready_o | output | 1 | Request accepted (always high) |
| req_cls_i | input | CLS_W | Class of the requester |
| req_set_i | input | SET_W | Set index |
| req_tag_i | input | TAG_W | Request tag |
| cfg_we_i | input | 1 | Mask write strobe |
| cfg_cls_i | input | CLS_W | Class whose mask is written |
| cfg_mask_i | input | WAYS | New way-allocation mask |
| rsp_valid_o | output | 1 | Response valid |
| rsp_hit_o | output | 1 | Request hit |
| rsp_way_o | output | WAY_W | Way that hit or was filled |
| rsp_evict_valid_o | output | 1 | A valid line was displaced |
| rsp_evict_tag_o | output | TAG_W | Tag of the displaced line |
| alloc_error_o | output | 1 | Miss with an empty mask |

## Verification
A mask write and a lookup by the same class can land in the same cycle. In that case the lookup must still see the old mask and fill inside it. The bench provokes this in a directed step that writes an empty mask together with a missing request. It then issues more such pairs at random throughout a long run, and a bench model applies each write only after predicting the coincident response. The second collision is between a hit and the victim walk in one set. A hit on a line outside the class's current mask must still refresh the tree. The next miss's victim, compared against the model, shows whether it did.

// File: rtl/wp_cache_pkg.sv
package wp_cache_pkg;
  typedef enum logic [1:0] {
    LK_IDLE = 2'd0,
    LK_HIT  = 2'd1,
    LK_FILL = 2'd2,
    LK_ERR  = 2'd3
  } lk_out_e;
endpackage

// File: rtl/wp_mask_regs.sv
module wp_mask_regs #(
  parameter int unsigned WAYS        = 8,
  parameter int unsigned CLASSES     = 4,
  parameter bit          SECURE_RST  = 1'b1,
  parameter int unsigned SECURE_WAYS = 2,
  localparam int unsigned CLS_W      = $clog2(CLASSES)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  logic [CLS_W-1:0]                cls_i,
  input  logic [WAYS-1:0]                 mask_i,
  output logic [CLASSES-1:0][WAYS-1:0]    masks_o
);
  localparam int unsigned SEC_CLS = CLASSES - 1;

  function automatic logic [WAYS-1:0] rst_mask(int unsigned c);
    logic [WAYS-1:0] m;
    for (int w = 0; w < WAYS; w++) begin
      if (!SECURE_RST) m[w] = 1'b1;
      else             m[w] = ((w >= int'(WAYS - SECURE_WAYS)) == (c == SEC_CLS));
    end
    return m;
  endfunction

  for (genvar c = 0; c < CLASSES; c++) begin : g_cls
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 masks_o[c] <= rst_mask(c);
      else if (we_i && cls_i == CLS_W'(c))         masks_o[c] <= mask_i;
    end
  end

  assert_mask_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> masks_o[$past(cls_i)] == $past(mask_i))
    else $error("mask write not applied");
endmodule

// File: rtl/wp_victim_pick.sv
module wp_victim_pick #(
  parameter int unsigned WAYS  = 8,
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-2:0]  plru_i,
  input  logic [WAYS-1:0]  allow_i,
  input  logic [WAYS-1:0]  valid_i,
  output logic [WAY_W-1:0] way_o,
  output logic             none_o
);
  logic [WAYS-1:0]  free;
  logic [WAY_W-1:0] free_way;
  logic [WAY_W-1:0] tree_way;

  always_comb begin
    int idx;
    int node;
    int span;
    logic lok, hok, d;
    free     = allow_i & ~valid_i;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) if (free[w]) free_way = w[WAY_W-1:0];
    idx = 0;
    for (int l = 0; l < WAY_W; l++) begin
      node = (1 << l) - 1 + idx;
      span = int'(WAYS) >> (l + 1);
      lok  = 1'b0;
      hok  = 1'b0;
      for (int w = 0; w < WAYS; w++) begin
        if (w / span == 2 * idx)     lok = lok | allow_i[w];
        if (w / span == 2 * idx + 1) hok = hok | allow_i[w];
      end
      d = plru_i[node];
      if (d && !hok)      d = 1'b0;
      else if (!d && !lok) d = 1'b1;
      idx = 2 * idx + int'(d);
    end
    tree_way = idx[WAY_W-1:0];
    way_o    = (|free) ? free_way : tree_way;
    none_o   = ~|allow_i;
    if (|allow_i) begin
      assert_victim_allowed_R3: assert (allow_i[way_o]) else $error("victim outside mask");
    end
  end
endmodule

// File: rtl/wp_plru_touch.sv
module wp_plru_touch #(
  parameter int unsigned WAYS  = 8,
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-2:0]  plru_i,
  input  logic [WAY_W-1:0] way_i,
  output logic [WAYS-2:0]  plru_o
);
  always_comb begin
    int idx;
    int node;
    logic d;
    plru_o = plru_i;
    idx    = 0;
    for (int l = 0; l < WAY_W; l++) begin
      node         = (1 << l) - 1 + idx;
      d            = way_i[WAY_W-1-l];
      plru_o[node] = ~d;
      idx          = 2 * idx + int'(d);
    end
  end
endmodule

// File: rtl/wp_cache_ctrl.sv
module wp_cache_ctrl
  import wp_cache_pkg::*;
#(
  parameter int unsigned SETS        = 16,
  parameter int unsigned WAYS        = 8,
  parameter int unsigned CLASSES     = 4,
  parameter int unsigned TAG_W       = 10,
  parameter bit          SECURE_RST  = 1'b1,
  parameter int unsigned SECURE_WAYS = 2,
  localparam int unsigned SET_W = $clog2(SETS),
  localparam int unsigned WAY_W = $clog2(WAYS),
  localparam int unsigned CLS_W = $clog2(CLASSES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [CLS_W-1:0] req_cls_i,
  input  logic [SET_W-1:0] req_set_i,
  input  logic [TAG_W-1:0] req_tag_i,
  input  logic             cfg_we_i,
  input  logic [CLS_W-1:0] cfg_cls_i,
  input  logic [WAYS-1:0]  cfg_mask_i,
  output logic             rsp_valid_o,
  output logic             rsp_hit_o,
  output logic [WAY_W-1:0] rsp_way_o,
  output logic             rsp_evict_valid_o,
  output logic [TAG_W-1:0] rsp_evict_tag_o,
  output logic             alloc_error_o
);
  logic [SETS-1:0][WAYS-1:0] valid_q;
  logic [SETS-1:0][WAYS-2:0] plru_q;
  logic [TAG_W-1:0]          tag_q [SETS][WAYS];

  logic [CLASSES-1:0][WAYS-1:0] masks;
  logic [WAYS-1:0]  allow, hit_vec;
  logic [WAY_W-1:0] hit_way, vic_way, touch_way;
  logic             hit, none;
  logic [WAYS-2:0]  plru_next;
  lk_out_e          outcome;

  logic [WAYS-1:0]  rsp_allow_q;

  assign req_ready_o = 1'b1;

  wp_mask_regs #(.WAYS(WAYS), .CLASSES(CLASSES), .SECURE_RST(SECURE_RST),
                 .SECURE_WAYS(SECURE_WAYS)) u_masks (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .cls_i(cfg_cls_i), .mask_i(cfg_mask_i),
    .masks_o(masks)
  );

  assign allow = masks[req_cls_i];

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      hit_vec[w] = valid_q[req_set_i][w] && tag_q[req_set_i][w] == req_tag_i;
    end
    for (int w = WAYS - 1; w >= 0; w--) if (hit_vec[w]) hit_way = w[WAY_W-1:0];
    hit = |hit_vec;
  end

  wp_victim_pick #(.WAYS(WAYS)) u_pick (
    .plru_i(plru_q[req_set_i]), .allow_i(allow), .valid_i(valid_q[req_set_i]),
    .way_o(vic_way), .none_o(none)
  );

  assign touch_way = hit ? hit_way : vic_way;

  wp_plru_touch #(.WAYS(WAYS)) u_touch (
    .plru_i(plru_q[req_set_i]), .way_i(touch_way), .plru_o(plru_next)
  );

  always_comb begin
    if (!req_valid_i) outcome = LK_IDLE;
    else if (hit)     outcome = LK_HIT;
    else if (none)    outcome = LK_ERR;
    else              outcome = LK_FILL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      plru_q  <= '0;
    end else begin
      if (outcome == LK_HIT || outcome == LK_FILL) plru_q[req_set_i] <= plru_next;
      if (outcome == LK_FILL) valid_q[req_set_i][vic_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (outcome == LK_FILL) tag_q[req_set_i][vic_way] <= req_tag_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o       <= 1'b0;
      rsp_hit_o         <= 1'b0;
      rsp_way_o         <= '0;
      rsp_evict_valid_o <= 1'b0;
      rsp_evict_tag_o   <= '0;
      alloc_error_o     <= 1'b0;
      rsp_allow_q       <= '0;
    end else begin
      rsp_valid_o       <= outcome != LK_IDLE;
      rsp_hit_o         <= outcome == LK_HIT;
      rsp_way_o         <= (outcome == LK_HIT) ? hit_way : (outcome == LK_FILL ? vic_way : '0);
      rsp_evict_valid_o <= outcome == LK_FILL && valid_q[req_set_i][vic_way];
      rsp_evict_tag_o   <= (outcome == LK_FILL && valid_q[req_set_i][vic_way])
                           ? tag_q[req_set_i][vic_way] : '0;
      alloc_error_o     <= outcome == LK_ERR;
      rsp_allow_q       <= allow;
    end
  end

  assert_rsp_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o) else $error("response missing");
  assert_no_spurious_rsp_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o) else $error("spurious response");
  assert_single_hit_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> $onehot0(hit_vec)) else $error("tag present twice");
  assert_fill_in_mask_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_hit_o && !alloc_error_o |-> rsp_allow_q[rsp_way_o])
    else $error("fill outside mask");
  assert_err_no_fill_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_error_o |-> rsp_allow_q == '0 && !rsp_hit_o && $stable(valid_q))
    else $error("error response changed lines");
endmodule

// File: tb/wp_cache_ctrl_tb.sv
`timescale 1ns/1ps
module wp_cache_ctrl_tb;
  localparam int SETS = 16, WAYS = 8, CLASSES = 4, TAG_W = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_cls = '0, cfg_cls = '0;
  logic [3:0] req_set = '0;
  logic [TAG_W-1:0] req_tag = '0, ev_tag;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_mask = '0;
  logic rsp_valid, rsp_hit, ev_valid, aerr;
  logic [2:0] rsp_way;

  always #4 clk = ~clk;

  wp_cache_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_cls_i(req_cls), .req_set_i(req_set), .req_tag_i(req_tag),
    .cfg_we_i(cfg_we), .cfg_cls_i(cfg_cls), .cfg_mask_i(cfg_mask),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_way_o(rsp_way),
    .rsp_evict_valid_o(ev_valid), .rsp_evict_tag_o(ev_tag), .alloc_error_o(aerr)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  bit       mvalid [SETS][WAYS];
  int       mtag   [SETS][WAYS];
  bit [6:0] mplru  [SETS];
  bit [7:0] mmask  [CLASSES];

  task automatic chk(string r, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  function automatic int m_victim(int s, bit [7:0] allow);
    int lo = 0, size = WAYS, node = 0, half;
    bit lok, hok, up;
    for (int w = 0; w < WAYS; w++) if (allow[w] && !mvalid[s][w]) return w;
    while (size > 1) begin
      half = size / 2;
      lok = 0; hok = 0;
      for (int w = lo; w < lo + half; w++) lok |= allow[w];
      for (int w = lo + half; w < lo + size; w++) hok |= allow[w];
      up = mplru[s][node];
      if (up && !hok) up = 0;
      else if (!up && !lok) up = 1;
      node = 2 * node + 1 + int'(up);
      if (up) lo += half;
      size = half;
    end
    return lo;
  endfunction

  task automatic m_touch(int s, int way);
    int lo = 0, size = WAYS, node = 0, half;
    bit up;
    while (size > 1) begin
      half = size / 2;
      up = way >= lo + half;
      mplru[s][node] = !up;
      node = 2 * node + 1 + int'(up);
      if (up) lo += half;
      size = half;
    end
  endtask

  // Issue one request (optionally with a coincident mask write) and check its response.
  task automatic do_req(int c, int s, int t, string r_way,
                        bit wcfg = 0, int cc = 0, bit [7:0] cm = 0);
    bit hit = 0, ev = 0, err = 0;
    int way = 0, evt = 0;
    bit [7:0] allow = mmask[c];
    for (int w = 0; w < WAYS; w++) if (mvalid[s][w] && mtag[s][w] == t) begin hit = 1; way = w; end
    if (!hit) begin
      if (allow == 0) err = 1;
      else begin
        way = m_victim(s, allow);
        ev  = mvalid[s][way];
        evt = ev ? mtag[s][way] : 0;
      end
    end
    req_valid = 1; req_cls = 2'(c); req_set = 4'(s); req_tag = TAG_W'(t);
    cfg_we = wcfg; cfg_cls = 2'(cc); cfg_mask = cm;
    @(negedge clk);
    req_valid = 0; cfg_we = 0;
    if (wcfg) mmask[cc] = cm;
    chk("R2", "rsp_valid", int'(rsp_valid), 1);
    chk("R1", "hit", int'(rsp_hit), int'(hit));
    if (!err) chk(hit ? "R1" : r_way, "way", int'(rsp_way), way);
    chk("R7", "evict_valid", int'(ev_valid), int'(ev));
    chk("R7", "evict_tag", int'(ev_tag), evt);
    chk("R8", "alloc_error", int'(aerr), int'(err));
    if (hit) m_touch(s, way);
    else if (!err) begin
      mvalid[s][way] = 1; mtag[s][way] = t; m_touch(s, way);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2417));
    for (int s = 0; s < SETS; s++) begin
      mplru[s] = '0;
      for (int w = 0; w < WAYS; w++) begin mvalid[s][w] = 0; mtag[s][w] = 0; end
    end
    for (int c = 0; c < CLASSES - 1; c++) mmask[c] = 8'h3F;
    mmask[CLASSES-1] = 8'hC0;

    repeat (3) @(negedge clk);
    chk("R11", "rsp_valid in reset", int'(rsp_valid), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R11", "rsp_valid after reset", int'(rsp_valid), 0);
    chk("R2", "req_ready", int'(req_ready), 1);

    // R4/R9: class 0 fills ways 0..5 of set 0 in order; ways 6,7 reserved
    for (int i = 0; i < 6; i++) begin
      do_req(0, 0, 1 + i, "R4");
      chk("R9", "class0 fill way", int'(rsp_way), i);
    end
    // R5/R3: class 0 full, victim from tree inside 0..5
    do_req(0, 0, 7, "R5");
    chk("R3", "victim below way 6", int'(rsp_way < 6), 1);
    chk("R7", "displaced line valid", int'(ev_valid), 1);
    // secure class lands in way 6
    do_req(3, 0, 9, "R4");
    chk("R9", "secure fill way", int'(rsp_way), 6);
    // R1: other class hits the secure line
    do_req(1, 0, 9, "R1");
    chk("R1", "cross-class hit", int'(rsp_hit), 1);

    // R6: hit refreshes tree before a victim pick
    for (int i = 0; i < 6; i++) do_req(0, 3, 40 + i, "R4");
    do_req(0, 3, 40, "R6");
    do_req(0, 3, 50, "R6");
    do_req(0, 3, 41, "R6");
    do_req(0, 3, 51, "R6");

    // R10: mask write to zero in the same cycle as a miss uses old mask
    do_req(2, 1, 20, "R10", 1, 2, 8'h00);
    chk("R10", "coincident fill not blocked", int'(aerr), 0);
    do_req(2, 1, 21, "R8");
    chk("R8", "empty mask error", int'(aerr), 1);
    do_req(0, 1, 21, "R4");
    chk("R8", "no fill on error", int'(rsp_hit), 0);
    // R10: shrink class 0, old line in way 5 still hits
    do_req(1, 2, 60, "R4", 1, 0, 8'h0F);
    do_req(0, 0, 6, "R10");
    chk("R10", "disallowed-way line hits", int'(rsp_hit), 1);
    do_req(0, 5, 70, "R4");
    do_req(0, 5, 71, "R4");

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      int c = int'($urandom_range(0, 3));
      int s = int'($urandom_range(0, 3));
      int t = int'($urandom_range(0, 11));
      if ($urandom_range(0, 19) == 0) begin
        bit [7:0] m = ($urandom_range(0, 4) == 0) ? 8'h00 : 8'($urandom);
        do_req(c, s, t, "R5", 1, int'($urandom_range(0, 3)), m);
      end else if ($urandom_range(0, 9) == 0) begin
        @(negedge clk);
        chk("R2", "idle no response", int'(rsp_valid), 0);
      end else begin
        do_req(c, s, t, "R5");
      end
    end
    finish_run();
  end
endmodule